// File: doc/BRIEF.md
# Glitchless Two-Clock Switchover Multiplexer

This block picks one of two free-running clocks, which have no fixed phase relation to each other, and drives it onto a single clock output. When the select input changes, the handoff goes through three stages. The output first keeps following the old clock until its enable is released on a falling edge. It then stays low while the new clock's lane counts falling edges. Only after that does it pass the new clock through. No high or low phase of the output is ever shorter than a half period of either source. The two inputs are handled the same way, so either one can act as the primary.

A static bypass control turns the block into a plain two-input mux that switches at once and has no protection. Each input also has a valid flag. When the flag of the selected input drops, the output stops toggling and holds high until the flag returns. Protected switching is specified only for source frequencies within 1.5:1 of each other.

Top module: `clk_switch_mux`

## Requirements
- R1: While rst_n is low and bypass is low, clk_out is low and neither input lane is enabled.
- R2: After reset is released, clk_out follows the clock chosen by sel_in (0 selects clk_in0, 1 selects clk_in1) within 20 periods of the slower clock.
- R3: With bypass low, no high or low phase of clk_out during a switchover is shorter than the shorter of the two source half periods.
- R4: After the old clock is released, clk_out stays low for at least two full periods of the new clock. A lane becomes enabled only after it has spent two of its own falling edges armed.
- R5: After sel_in changes, clk_out keeps following the old clock for at least two of its full periods. A lane releases only on a falling edge of its clock, and only once its synchronized select shows it deselected.
- R6: Switching from clk_in1 to clk_in0 gives the same protected sequence and result as switching from clk_in0 to clk_in1.
- R7: A switchover completes within 20 periods of the slower clock. From then on clk_out equals the newly selected clock.
- R8: The two lane enables are never high at the same time.
- R9: With bypass high, clk_out equals clk_in1 when sel_in is 1 and clk_in0 when sel_in is 0, and follows a change of sel_in at once.
- R10: With bypass low, when src_ok bit i is low for the selected input i, clk_out stops toggling and stays high within three rising edges of that clock. It resumes following the clock once the bit returns high.
- R11: A low src_ok bit for the input that is not selected has no effect on clk_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in0 | input | 1 | Source clock 0 |
| clk_in1 | input | 1 | Source clock 1 |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 1 | Asynchronous source select, 1 picks clk_in1 |
| bypass | input | 1 | Static control; high makes the block a plain combinational mux |
| src_ok | input | 2 | Per-input valid flags, bit i belongs to clk_in i |
| clk_out | output | 1 | Output clock |

## Verification
The assertions assume that sel_in stays stable until a handoff has finished and that bypass is changed only when no handoff is in progress. Under those conditions the lane synchronizers cannot see a reversal part-way through an armed count. The stimulus waits a random number of reference cycles before each switch and then leaves select untouched for 40 reference cycles, which is well beyond the settling bound. The source clocks keep a 1.34:1 ratio, and their edges never coincide with the bench's sampling instants.

// File: rtl/ckmux_pkg.sv
package ckmux_pkg;

  typedef enum logic [1:0] {
    LN_OFF = 2'd0,
    LN_ARM = 2'd1,
    LN_ON  = 2'd2
  } lane_state_e;

  // width of the armed-edge counter for a given hold length
  function automatic int unsigned cnt_width(int unsigned hold_edges);
    return (hold_edges <= 2) ? 1 : $clog2(hold_edges);
  endfunction

  // lane idx is wanted when select points at it
  function automatic logic lane_wanted(logic sel, int unsigned idx);
    return (idx == 1) ? sel : !sel;
  endfunction

  // true once the armed counter has seen the last hold edge
  function automatic logic hold_done(int unsigned cnt, int unsigned hold_edges);
    return cnt == (hold_edges - 1);
  endfunction

endpackage

// File: rtl/ckmux_sync.sv
module ckmux_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RST_VAL   = 1'b0,
  parameter bit          FALL_EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  if (FALL_EDGE) begin : g_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
    end
  end else begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ckmux_lane.sv
module ckmux_lane
  import ckmux_pkg::*;
#(
  parameter int unsigned LANE_IDX    = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_EDGES  = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic sel_async,
  input  logic peer_en_async,
  input  logic ok_async,
  output logic en,
  output logic arm,
  output logic want_s,
  output logic cnt_last,
  output logic frz
);

  localparam int unsigned CW = cnt_width(HOLD_EDGES);

  lane_state_e     st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            want_raw;
  logic            peer_s;
  logic            ok_s;

  assign want_raw = lane_wanted(sel_async, LANE_IDX);

  // select and peer enable move into this clock's falling-edge domain
  ckmux_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_EDGE(1'b1)) u_want_sync (
    .clk(src_clk), .rst_n(rst_n), .d(want_raw), .q(want_s)
  );

  ckmux_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_EDGE(1'b1)) u_peer_sync (
    .clk(src_clk), .rst_n(rst_n), .d(peer_en_async), .q(peer_s)
  );

  // valid flag is taken on rising edges so the freeze engages while the clock is high
  ckmux_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALL_EDGE(1'b0)) u_ok_sync (
    .clk(src_clk), .rst_n(rst_n), .d(ok_async), .q(ok_s)
  );

  assign frz = ~ok_s;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      LN_OFF: begin
        if (want_s && !peer_s) begin
          st_d  = LN_ARM;
          cnt_d = '0;
        end
      end
      LN_ARM: begin
        if (!want_s || peer_s) begin
          st_d  = LN_OFF;
          cnt_d = '0;
        end else if (hold_done(int'(cnt_q), HOLD_EDGES)) begin
          st_d  = LN_ON;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      LN_ON: begin
        if (!want_s) st_d = LN_OFF;
      end
      default: begin
        st_d  = LN_OFF;
        cnt_d = '0;
      end
    endcase
  end

  // state moves only on falling edges, so enable changes while the clock is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign en       = (st_q == LN_ON);
  assign arm      = (st_q == LN_ARM);
  assign cnt_last = hold_done(int'(cnt_q), HOLD_EDGES);

endmodule

// File: rtl/clk_switch_mux.sv
module clk_switch_mux
  import ckmux_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_EDGES  = 2
) (
  input  logic       clk_in0,
  input  logic       clk_in1,
  input  logic       rst_n,
  input  logic       sel_in,
  input  logic       bypass,
  input  logic [1:0] src_ok,
  output logic       clk_out
);

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] lane_en;
  logic [NUM_SRC-1:0] lane_arm;
  logic [NUM_SRC-1:0] lane_want;
  logic [NUM_SRC-1:0] lane_cnt_last;
  logic [NUM_SRC-1:0] lane_frz;
  logic [NUM_SRC-1:0] lane_gated;
  logic               prot_clk;
  logic               raw_clk;

  assign src_clk = {clk_in1, clk_in0};

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_lane
    ckmux_lane #(
      .LANE_IDX   (gi),
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_EDGES (HOLD_EDGES)
    ) u_lane (
      .src_clk      (src_clk[gi]),
      .rst_n        (rst_n),
      .sel_async    (sel_in),
      .peer_en_async(lane_en[NUM_SRC-1-gi]),
      .ok_async     (src_ok[gi]),
      .en           (lane_en[gi]),
      .arm          (lane_arm[gi]),
      .want_s       (lane_want[gi]),
      .cnt_last     (lane_cnt_last[gi]),
      .frz          (lane_frz[gi])
    );

    // a frozen lane forces its gated clock high
    assign lane_gated[gi] = lane_en[gi] & (src_clk[gi] | lane_frz[gi]);
  end

  assign prot_clk = |lane_gated;
  assign raw_clk  = sel_in ? clk_in1 : clk_in0;
  assign clk_out  = bypass ? raw_clk : prot_clk;

endmodule

// File: rtl/clk_switch_mux_chk.sv
module clk_switch_mux_chk (
  input logic       clk_in0,
  input logic       clk_in1,
  input logic       rst_n,
  input logic       bypass,
  input logic       clk_out,
  input logic [1:0] lane_en,
  input logic [1:0] lane_arm,
  input logic [1:0] lane_want,
  input logic [1:0] lane_cnt_last,
  input logic [1:0] lane_frz
);

  logic [1:0] ck;
  assign ck = {clk_in1, clk_in0};

  for (genvar gi = 0; gi < 2; gi++) begin : g_chk
    // R8
    excl_chk: assert property (@(posedge ck[gi]) disable iff (!rst_n)
      !(lane_en[0] && lane_en[1]));

    // R4
    hold_chk: assert property (@(negedge ck[gi]) disable iff (!rst_n)
      $rose(lane_en[gi]) |-> ($past(lane_arm[gi]) && $past(lane_cnt_last[gi])));

    // R5
    release_chk: assert property (@(negedge ck[gi]) disable iff (!rst_n)
      $fell(lane_en[gi]) |-> !$past(lane_want[gi]));

    // R10
    freeze_chk: assert property (@(posedge ck[gi]) disable iff (!rst_n || bypass)
      (lane_en[gi] && lane_frz[gi]) |-> clk_out);
  end

endmodule

bind clk_switch_mux clk_switch_mux_chk u_chk (
  .clk_in0      (clk_in0),
  .clk_in1      (clk_in1),
  .rst_n        (rst_n),
  .bypass       (bypass),
  .clk_out      (clk_out),
  .lane_en      (lane_en),
  .lane_arm     (lane_arm),
  .lane_want    (lane_want),
  .lane_cnt_last(lane_cnt_last),
  .lane_frz     (lane_frz)
);

// File: tb/test_clk_switch_mux.sv
`timescale 1ps/1ps
module test_clk_switch_mux;

  localparam int HP0      = 3300;   // clk_in0 half period
  localparam int HP1      = 4410;   // clk_in1 half period
  localparam int REF_HALF = 2500;   // 200 MHz reference
  localparam int LIMIT    = 150000;

  logic       clk = 1'b0;
  logic       clk_in0 = 1'b0;
  logic       clk_in1 = 1'b0;
  logic       rst_n = 1'b1;
  logic       sel_in = 1'b0;
  logic       bypass = 1'b0;
  logic [1:0] src_ok = 2'b11;
  wire        clk_out;

  always #REF_HALF clk = ~clk;
  initial begin #130; forever #HP0 clk_in0 = ~clk_in0; end
  initial begin #773; forever #HP1 clk_in1 = ~clk_in1; end

  clk_switch_mux i_clk_switch_mux (
    .clk_in0(clk_in0), .clk_in1(clk_in1), .rst_n(rst_n), .sel_in(sel_in),
    .bypass(bypass), .src_ok(src_ok), .clk_out(clk_out)
  );

  int     checks = 0;
  int     errors = 0;
  int     mode = 0;        // 0 idle, 1 follow selected, 2 held high, 3 low, 5 follow old
  string  tag = "R1";
  logic   model_sel = 1'b0;
  logic   old_sel = 1'b0;
  longint last_t = 0;
  longint max_low = 0;
  int     runts = 0;
  bit     measuring = 1'b0;
  int     edges = 0;
  int     cyc = 0;
  bit     done = 1'b0;

  // phase-width monitor on the output
  always @(clk_out) begin
    longint w;
    w = longint'($time) - last_t;
    if (measuring) begin
      if (w < HP0) runts++;
      if (clk_out === 1'b1 && w > max_low) max_low = w;
    end
    edges++;
    last_t = longint'($time);
  end

  // reference model comparison on every reference clock
  always @(negedge clk) begin
    logic exp_v;
    if (mode != 0 && !done) begin
      case (mode)
        1:       exp_v = model_sel ? clk_in1 : clk_in0;
        2:       exp_v = 1'b1;
        3:       exp_v = 1'b0;
        default: exp_v = old_sel ? clk_in1 : clk_in0;
      endcase
      checks++;
      if (clk_out !== exp_v) begin
        errors++;
        $display("FAIL %s clk_out actual %b expected %b at %0t", tag, clk_out, exp_v, $time);
      end
    end
  end

  task automatic expect_ok(string rq, bit cond, longint act, longint exp_v);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", rq, act, exp_v, $time);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  // protected switch with stage checks: R3, R4, R5, R6, R7
  task automatic do_switch(logic ns);
    longint new_period;
    new_period = ns ? 2 * HP1 : 2 * HP0;
    cycles(1 + int'($urandom_range(0, 6)));
    old_sel   = model_sel;
    runts     = 0;
    max_low   = 0;
    measuring = 1'b1;
    tag       = "R5";
    mode      = 5;
    sel_in    = ns;
    model_sel = ns;
    cycles(2);
    mode = 0;
    cycles(40);
    measuring = 1'b0;
    expect_ok("R3 runt phases", runts == 0, runts, 0);
    expect_ok("R4 low hold ps", max_low >= 2 * new_period, max_low, 2 * new_period);
    tag  = ns ? "R7" : "R6";
    mode = 1;
    cycles(20);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(posedge clk);
    tag  = "R1";
    mode = 3;
    cycles(8);
    mode  = 0;
    rst_n = 1'b1;
    cycles(30);
    tag  = "R2";
    mode = 1;
    cycles(20);

    for (int k = 0; k < 6; k++) do_switch(~model_sel);

    // R11: unselected valid flag low
    tag       = "R11";
    src_ok[1] = 1'b0;
    cycles(20);
    src_ok[1] = 1'b1;
    cycles(10);

    // R10: selected input flagged invalid
    mode      = 0;
    src_ok[0] = 1'b0;
    cycles(6);
    edges = 0;
    tag   = "R10";
    mode  = 2;
    cycles(20);
    mode = 0;
    expect_ok("R10 edges while frozen", edges == 0, edges, 0);
    src_ok[0] = 1'b1;
    cycles(10);
    mode = 1;
    cycles(20);

    // R9: bypass
    mode   = 0;
    bypass = 1'b1;
    tag    = "R9";
    mode   = 1;
    cycles(10);
    sel_in    = 1'b1;
    model_sel = 1'b1;
    #1;
    expect_ok("R9 immediate to in1", clk_out === clk_in1, clk_out, clk_in1);
    cycles(40);
    sel_in    = 1'b0;
    model_sel = 1'b0;
    #1;
    expect_ok("R9 immediate to in0", clk_out === clk_in0, clk_out, clk_in0);
    cycles(40);
    mode   = 0;
    bypass = 1'b0;
    cycles(4);
    tag  = "R7";
    mode = 1;
    cycles(20);

    // R1: reset during operation
    mode  = 0;
    rst_n = 1'b0;
    cycles(1);
    tag  = "R1";
    mode = 3;
    cycles(5);
    mode = 0;
    finish_run();
  end

endmodule